// File: doc/BRIEF.md
# Host/DSP Mailbox Access Port

This block sits between an 8-bit host register bus and two 256-byte mailbox memories. One mailbox carries bytes from the DSP to the host, and the other carries bytes from the host to the DSP. The host never addresses mailbox memory directly. It loads a read pointer or a write pointer, then moves data through a single shared data offset. Each access to that offset steps the matching pointer, and a pointer that steps past the last location wraps to zero.

A pair of 8-bit soft-interrupt vector registers and a 16-bit command word let host software and DSP firmware signal each other. When the host writes its vector, an interrupt is raised toward the DSP. That interrupt stays up until the DSP reads the vector. When the DSP writes its acknowledge vector, a host interrupt is raised, and it stays up until the host reads that vector. The DSP side is a simple synchronous port: it can fill the outgoing mailbox, drain the incoming mailbox, write its acknowledge vector and read the host vector.

Top module: `hdmbx_port`

## Requirements
- R1: After reset, both pointers are 00h, the command word and both vectors are 0, dsp_int_o and host_int_o are low, and host_rdata_o is 00h.
- R2: A host write to offset 48h loads the read pointer, and a host write to offset 4Ah loads the write pointer. Each offset returns its pointer's current value on a host read. Every host read returns its data on host_rdata_o one cycle after the read strobe, and the value holds until the next read.
- R3: A host read of offset 4Ch returns the DSP-to-host mailbox byte at the read pointer, and then the read pointer increases by one.
- R4: A host write to offset 4Ch stores the byte in the host-to-DSP mailbox at the write pointer, and then the write pointer increases by one. A DSP read (dsp_in_re_i) at dsp_addr_i returns that byte on dsp_in_rdata_o one cycle later.
- R5: A pointer that steps past FFh wraps to 00h.
- R6: A pointer changes only on a write to its own offset or on the matching direction of access to 4Ch. Accesses to any other offset leave both pointers unchanged.
- R7: The command word's low byte sits at offset 60h and its high byte at 61h. The host can write both bytes and read them back, and the whole word appears on dsp_cmd_o.
- R8: A host write to offset 64h stores the host vector, which appears on dsp_vec_o, and raises dsp_int_o. dsp_int_o stays high until dsp_vec_rd_i is pulsed. If a new host write arrives in the same cycle as that pulse, the interrupt stays set.
- R9: A DSP write (dsp_ack_we_i) stores the acknowledge vector and raises host_int_o. The host reads that vector at offset 66h, and the read clears host_int_o.
- R10: The DSP writes the DSP-to-host mailbox at dsp_addr_i with dsp_out_we_i. DSP and host accesses are never blocked. If the host reads a location in the same cycle that the DSP writes it, the host gets the old byte.
- R11: A host read of any offset that is not mapped returns 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_addr_i | input | 8 | Host register offset |
| host_wr_i | input | 1 | Host write strobe |
| host_rd_i | input | 1 | Host read strobe |
| host_wdata_i | input | DW | Host write data |
| host_rdata_o | output | DW | Host read data, valid one cycle after the strobe |
| host_int_o | output | 1 | Acknowledge vector pending toward the host |
| dsp_addr_i | input | AW | DSP mailbox address |
| dsp_out_we_i | input | 1 | DSP write to the DSP-to-host mailbox |
| dsp_out_wdata_i | input | DW | DSP write data |
| dsp_in_re_i | input | 1 | DSP read of the host-to-DSP mailbox |
| dsp_in_rdata_o | output | DW | DSP read data, valid one cycle after the strobe |
| dsp_ack_we_i | input | 1 | DSP writes its acknowledge vector |
| dsp_ack_vec_i | input | DW | Acknowledge vector value |
| dsp_vec_rd_i | input | 1 | DSP read of the host vector; clears dsp_int_o |
| dsp_vec_o | output | DW | Host vector value |
| dsp_int_o | output | 1 | Soft interrupt toward the DSP |
| dsp_cmd_o | output | 2*DW | Command word |

## Verification
The hardest cases to reach are the ones where both sides act in the same cycle. In one, the DSP overwrites the very location the host is reading. In the other, the host posts a new vector in the same cycle that the DSP reads the old one. The bench drives both ports in the same clock cycle to create each case. It then reads the location again to confirm that the new byte has landed. The pointer wrap is reached by loading a pointer with FEh and stepping it past FFh, which avoids 256 accesses.

// File: rtl/hdmbx_pkg.sv
package hdmbx_pkg;
  localparam int unsigned REG_AW = 8;
  typedef logic [REG_AW-1:0] reg_addr_t;

  localparam reg_addr_t OFS_RPTR   = 8'h48;
  localparam reg_addr_t OFS_WPTR   = 8'h4A;
  localparam reg_addr_t OFS_DATA   = 8'h4C;
  localparam reg_addr_t OFS_CMD_LO = 8'h60;
  localparam reg_addr_t OFS_CMD_HI = 8'h61;
  localparam reg_addr_t OFS_HVEC   = 8'h64;
  localparam reg_addr_t OFS_DVEC   = 8'h66;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_RPTR, SEL_WPTR, SEL_CMD_LO,
    SEL_CMD_HI, SEL_HVEC, SEL_DVEC, SEL_DATA
  } rsel_e;
endpackage

// File: rtl/hdmbx_ram.sv
module hdmbx_ram #(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          re_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];
  logic [DW-1:0] rdata_q;

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  // old data on a same-address collision
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (re_i) rdata_q <= mem_q[raddr_i];
  end

  assign rdata_o = rdata_q;

  AST_RAM_RD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_i |=> $stable(rdata_q)); // R2
endmodule

// File: rtl/hdmbx_ptr.sv
module hdmbx_ptr #(
  parameter int unsigned AW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ld_i,
  input  logic [AW-1:0] ld_val_i,
  input  logic          inc_i,
  output logic [AW-1:0] ptr_o
);
  logic [AW-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ptr_q <= '0;
    else if (ld_i)   ptr_q <= ld_val_i;
    else if (inc_i)  ptr_q <= ptr_q + AW'(1);  // natural wrap
  end

  assign ptr_o = ptr_q;

  AST_PTR_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_i |=> ptr_q == $past(ld_val_i)); // R2
  AST_PTR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i && !ld_i && ptr_q == '1 |=> ptr_q == '0); // R5
  AST_PTR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inc_i && !ld_i |=> $stable(ptr_q)); // R6
endmodule

// File: rtl/hdmbx_flag.sv
module hdmbx_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;

  // set wins over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_q <= 1'b0;
    else if (set_i)  flag_q <= 1'b1;
    else if (clr_i)  flag_q <= 1'b0;
  end

  assign flag_o = flag_q;

  AST_FLAG_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> flag_q); // R8
  AST_FLAG_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i && !set_i |=> !flag_q); // R9
  AST_FLAG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !set_i && !clr_i |=> $stable(flag_q)); // R8
endmodule

// File: rtl/hdmbx_port.sv
module hdmbx_port
  import hdmbx_pkg::*;
#(
  parameter int unsigned DW = 8,
  parameter int unsigned AW = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [REG_AW-1:0]    host_addr_i,
  input  logic                 host_wr_i,
  input  logic                 host_rd_i,
  input  logic [DW-1:0]        host_wdata_i,
  output logic [DW-1:0]        host_rdata_o,
  output logic                 host_int_o,
  input  logic [AW-1:0]        dsp_addr_i,
  input  logic                 dsp_out_we_i,
  input  logic [DW-1:0]        dsp_out_wdata_i,
  input  logic                 dsp_in_re_i,
  output logic [DW-1:0]        dsp_in_rdata_o,
  input  logic                 dsp_ack_we_i,
  input  logic [DW-1:0]        dsp_ack_vec_i,
  input  logic                 dsp_vec_rd_i,
  output logic [DW-1:0]        dsp_vec_o,
  output logic                 dsp_int_o,
  output logic [2*DW-1:0]      dsp_cmd_o
);
  localparam int unsigned CW = 2 * DW;

  rsel_e         sel;
  logic [AW-1:0] rptr, wptr;
  logic [DW-1:0] mem_rdata;
  logic [DW-1:0] reg_mux, reg_rdata_q;
  logic          rd_mem_q;
  logic [CW-1:0] cmd_q;
  logic [DW-1:0] hvec_q, dvec_q;

  always_comb begin
    unique case (host_addr_i)
      OFS_RPTR:   sel = SEL_RPTR;
      OFS_WPTR:   sel = SEL_WPTR;
      OFS_DATA:   sel = SEL_DATA;
      OFS_CMD_LO: sel = SEL_CMD_LO;
      OFS_CMD_HI: sel = SEL_CMD_HI;
      OFS_HVEC:   sel = SEL_HVEC;
      OFS_DVEC:   sel = SEL_DVEC;
      default:    sel = SEL_NONE;
    endcase
  end

  logic wr_rptr, wr_wptr, wr_data, rd_data, wr_hvec, rd_dvec;
  assign wr_rptr = host_wr_i && sel == SEL_RPTR;
  assign wr_wptr = host_wr_i && sel == SEL_WPTR;
  assign wr_data = host_wr_i && sel == SEL_DATA;
  assign rd_data = host_rd_i && sel == SEL_DATA;
  assign wr_hvec = host_wr_i && sel == SEL_HVEC;
  assign rd_dvec = host_rd_i && sel == SEL_DVEC;

  hdmbx_ptr #(.AW(AW)) u_rptr (
    .clk_i, .rst_ni, .ld_i(wr_rptr), .ld_val_i(AW'(host_wdata_i)),
    .inc_i(rd_data), .ptr_o(rptr));

  hdmbx_ptr #(.AW(AW)) u_wptr (
    .clk_i, .rst_ni, .ld_i(wr_wptr), .ld_val_i(AW'(host_wdata_i)),
    .inc_i(wr_data), .ptr_o(wptr));

  // DSP -> host mailbox
  hdmbx_ram #(.AW(AW), .DW(DW)) u_mbx_out (
    .clk_i, .rst_ni,
    .we_i(dsp_out_we_i), .waddr_i(dsp_addr_i), .wdata_i(dsp_out_wdata_i),
    .re_i(rd_data), .raddr_i(rptr), .rdata_o(mem_rdata));

  // host -> DSP mailbox
  hdmbx_ram #(.AW(AW), .DW(DW)) u_mbx_in (
    .clk_i, .rst_ni,
    .we_i(wr_data), .waddr_i(wptr), .wdata_i(host_wdata_i),
    .re_i(dsp_in_re_i), .raddr_i(dsp_addr_i), .rdata_o(dsp_in_rdata_o));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q  <= '0;
      hvec_q <= '0;
      dvec_q <= '0;
    end else begin
      if (host_wr_i && sel == SEL_CMD_LO) cmd_q[DW-1:0]  <= host_wdata_i;
      if (host_wr_i && sel == SEL_CMD_HI) cmd_q[CW-1:DW] <= host_wdata_i;
      if (wr_hvec)      hvec_q <= host_wdata_i;
      if (dsp_ack_we_i) dvec_q <= dsp_ack_vec_i;
    end
  end

  hdmbx_flag u_dsp_int (
    .clk_i, .rst_ni, .set_i(wr_hvec), .clr_i(dsp_vec_rd_i), .flag_o(dsp_int_o));

  hdmbx_flag u_host_int (
    .clk_i, .rst_ni, .set_i(dsp_ack_we_i), .clr_i(rd_dvec), .flag_o(host_int_o));

  always_comb begin
    unique case (sel)
      SEL_RPTR:   reg_mux = DW'(rptr);
      SEL_WPTR:   reg_mux = DW'(wptr);
      SEL_CMD_LO: reg_mux = cmd_q[DW-1:0];
      SEL_CMD_HI: reg_mux = cmd_q[CW-1:DW];
      SEL_HVEC:   reg_mux = hvec_q;
      SEL_DVEC:   reg_mux = dvec_q;
      default:    reg_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_mem_q    <= 1'b0;
      reg_rdata_q <= '0;
    end else if (host_rd_i) begin
      rd_mem_q    <= sel == SEL_DATA;
      reg_rdata_q <= reg_mux;
    end
  end

  assign host_rdata_o = rd_mem_q ? mem_rdata : reg_rdata_q;
  assign dsp_vec_o    = hvec_q;
  assign dsp_cmd_o    = cmd_q;

  AST_UNMAPPED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_rd_i && sel == SEL_NONE |=> host_rdata_o == '0); // R11
  AST_RDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !host_rd_i |=> $stable(host_rdata_o) || $past(dsp_out_we_i)); // R2
  AST_WPTR_IDLE_ON_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_rd_i && !host_wr_i |=> $stable(wptr)); // R6
endmodule

// File: tb/sim_hdmbx_port.sv
module sim_hdmbx_port;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] host_addr_i = '0;
  logic       host_wr_i = 1'b0, host_rd_i = 1'b0;
  logic [7:0] host_wdata_i = '0;
  logic [7:0] host_rdata_o;
  logic       host_int_o;
  logic [7:0] dsp_addr_i = '0;
  logic       dsp_out_we_i = 1'b0;
  logic [7:0] dsp_out_wdata_i = '0;
  logic       dsp_in_re_i = 1'b0;
  logic [7:0] dsp_in_rdata_o;
  logic       dsp_ack_we_i = 1'b0;
  logic [7:0] dsp_ack_vec_i = '0;
  logic       dsp_vec_rd_i = 1'b0;
  logic [7:0] dsp_vec_o;
  logic       dsp_int_o;
  logic [15:0] dsp_cmd_o;

  int errors = 0, checks = 0;

  always #5 clk_i = ~clk_i;

  hdmbx_port u0 (.*);

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hwr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk_i); host_addr_i = a; host_wdata_i = d; host_wr_i = 1'b1;
    @(negedge clk_i); host_wr_i = 1'b0;
  endtask

  task automatic hrd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk_i); host_addr_i = a; host_rd_i = 1'b1;
    @(negedge clk_i); host_rd_i = 1'b0; d = host_rdata_o;
  endtask

  task automatic dwr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk_i); dsp_addr_i = a; dsp_out_wdata_i = d; dsp_out_we_i = 1'b1;
    @(negedge clk_i); dsp_out_we_i = 1'b0;
  endtask

  task automatic drd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk_i); dsp_addr_i = a; dsp_in_re_i = 1'b1;
    @(negedge clk_i); dsp_in_re_i = 1'b0; d = dsp_in_rdata_o;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    check("R1 rdata", host_rdata_o, 0);
    check("R1 dsp_int", dsp_int_o, 0);
    check("R1 host_int", host_int_o, 0);
    check("R1 cmd", dsp_cmd_o, 0);
    check("R1 vec", dsp_vec_o, 0);
    hrd(8'h48, d); check("R1 rptr", d, 0);
    hrd(8'h4A, d); check("R1 wptr", d, 0);
  endtask

  task automatic t_ptr_load;
    logic [7:0] d;
    hwr(8'h48, 8'h10); hrd(8'h48, d); check("R2 rptr load", d, 8'h10);
    hwr(8'h4A, 8'h20); hrd(8'h4A, d); check("R2 wptr load", d, 8'h20);
    repeat (3) @(negedge clk_i);
    check("R2 rdata hold", host_rdata_o, 8'h20);
  endtask

  task automatic t_host_read;
    logic [7:0] d;
    logic [7:0] pat [4] = '{8'hA5, 8'h5A, 8'h3C, 8'hC3};
    for (int i = 0; i < 4; i++) dwr(8'h10 + 8'(i), pat[i]);
    for (int i = 0; i < 4; i++) begin
      hrd(8'h4C, d); check("R3 data R10 dsp fill", d, pat[i]);
    end
    hrd(8'h48, d); check("R3 rptr step", d, 8'h14);
    hrd(8'h4A, d); check("R6 wptr untouched", d, 8'h20);
  endtask

  task automatic t_host_write;
    logic [7:0] d;
    hwr(8'h4C, 8'h11); hwr(8'h4C, 8'h22); hwr(8'h4C, 8'h33);
    drd(8'h20, d); check("R4 byte0", d, 8'h11);
    drd(8'h21, d); check("R4 byte1", d, 8'h22);
    drd(8'h22, d); check("R4 byte2", d, 8'h33);
    hrd(8'h4A, d); check("R4 wptr step", d, 8'h23);
    hrd(8'h48, d); check("R6 rptr untouched", d, 8'h14);
  endtask

  task automatic t_wrap;
    logic [7:0] d;
    dwr(8'hFE, 8'h61); dwr(8'hFF, 8'h62); dwr(8'h00, 8'h63);
    hwr(8'h48, 8'hFE);
    hrd(8'h4C, d); check("R5 rd FE", d, 8'h61);
    hrd(8'h4C, d); check("R5 rd FF", d, 8'h62);
    hrd(8'h4C, d); check("R5 rd 00", d, 8'h63);
    hrd(8'h48, d); check("R5 rptr wrap", d, 8'h01);
    hwr(8'h4A, 8'hFF);
    hwr(8'h4C, 8'h71); hwr(8'h4C, 8'h72);
    drd(8'hFF, d); check("R5 wr FF", d, 8'h71);
    drd(8'h00, d); check("R5 wr 00", d, 8'h72);
    hrd(8'h4A, d); check("R5 wptr wrap", d, 8'h01);
  endtask

  task automatic t_cmd;
    logic [7:0] d;
    hwr(8'h60, 8'h34); hwr(8'h61, 8'h12);
    check("R7 dsp_cmd", dsp_cmd_o, 16'h1234);
    hrd(8'h60, d); check("R7 lo", d, 8'h34);
    hrd(8'h61, d); check("R7 hi", d, 8'h12);
    hwr(8'h50, 8'hEE); hrd(8'h50, d);
    hrd(8'h48, d); check("R6 rptr after other", d, 8'h01);
    hrd(8'h4A, d); check("R6 wptr after other", d, 8'h01);
  endtask

  task automatic t_softint;
    logic [7:0] d;
    hwr(8'h64, 8'h9C);
    check("R8 int set", dsp_int_o, 1);
    check("R8 vec", dsp_vec_o, 8'h9C);
    repeat (4) @(negedge clk_i);
    check("R8 int held", dsp_int_o, 1);
    hrd(8'h64, d); check("R8 host readback", d, 8'h9C);
    @(negedge clk_i); dsp_vec_rd_i = 1'b1;
    @(negedge clk_i); dsp_vec_rd_i = 1'b0;
    check("R8 int cleared", dsp_int_o, 0);
    // clear and new set in one cycle: set wins
    hwr(8'h64, 8'h01);
    @(negedge clk_i);
    host_addr_i = 8'h64; host_wdata_i = 8'h02; host_wr_i = 1'b1; dsp_vec_rd_i = 1'b1;
    @(negedge clk_i); host_wr_i = 1'b0; dsp_vec_rd_i = 1'b0;
    check("R8 set wins", dsp_int_o, 1);
    check("R8 new vec", dsp_vec_o, 8'h02);
  endtask

  task automatic t_ack;
    logic [7:0] d;
    @(negedge clk_i); dsp_ack_vec_i = 8'h47; dsp_ack_we_i = 1'b1;
    @(negedge clk_i); dsp_ack_we_i = 1'b0;
    check("R9 host_int set", host_int_o, 1);
    hrd(8'h66, d); check("R9 vec", d, 8'h47);
    check("R9 host_int clear", host_int_o, 0);
  endtask

  task automatic t_unmapped;
    logic [7:0] d;
    hrd(8'h66, d);
    hrd(8'h51, d); check("R11 unmapped 51", d, 0);
    hrd(8'hFF, d); check("R11 unmapped FF", d, 0);
  endtask

  task automatic t_collision;
    logic [7:0] d;
    dwr(8'h80, 8'hAA);
    hwr(8'h48, 8'h80);
    @(negedge clk_i);
    host_addr_i = 8'h4C; host_rd_i = 1'b1;
    dsp_addr_i = 8'h80; dsp_out_wdata_i = 8'hBB; dsp_out_we_i = 1'b1;
    @(negedge clk_i); host_rd_i = 1'b0; dsp_out_we_i = 1'b0;
    check("R10 old data", host_rdata_o, 8'hAA);
    hwr(8'h48, 8'h80);
    hrd(8'h4C, d); check("R10 new data", d, 8'hBB);
  endtask

  initial begin
    #2000000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_ptr_load();
    t_host_read();
    t_host_write();
    t_wrap();
    t_cmd();
    t_softint();
    t_ack();
    t_unmapped();
    t_collision();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule